// File: doc/BRIEF.md
# I2C Target Register Access Interface

This block is an I2C target that lets a bus controller read and write a byte-wide register space of up to 65,536 locations. It samples SCL and SDA with the system clock through a small synchronizer, finds start, repeated start and stop conditions and SCL edges in the synchronized samples, and runs a single state machine that frames bytes, matches the 7-bit device address, generates acknowledges and keeps a 16-bit register pointer. SDA is driven only as an open-drain pull-down enable (`sda_oe` high pulls the line low).

On the register side the block drives a simple synchronous port. A write is a one-cycle `reg_we` pulse with `reg_addr` and `reg_wdata` valid in the same cycle. A read is a one-cycle `reg_re` pulse with `reg_addr` valid in that cycle; the register file must present `reg_rdata` in the cycle that follows. The pointer advances by one after every strobe. Reads are fetched ahead: the strobe for a byte goes out as soon as the controller has asked for it, so the byte is ready before its first SCL rising edge.

The state machine has twelve states. ST_IDLE waits for a start. Any start moves to ST_DEVADDR and any stop moves to ST_IDLE, from every state and at any bit. ST_DEVADDR receives the address byte; on a match it goes to ST_DEVACK (and issues the first read strobe when the direction bit is 1), otherwise to ST_SKIP, which stays silent until the next start or stop. ST_DEVACK goes to ST_RDATA for a read or to ST_PTRH for a write. The write path runs ST_PTRH, ST_PTRH_ACK, ST_PTRL, ST_PTRL_ACK (the pointer is loaded here), then alternates ST_WDATA and ST_WDATA_ACK (the write strobe is issued on entry to ST_WDATA_ACK) with no limit on the number of bytes. The read path alternates ST_RDATA and ST_RD_ACK. In ST_RD_ACK, an acknowledge from the controller issues the next read strobe and returns to ST_RDATA. A missing acknowledge sends the machine to ST_SKIP.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, `sda_oe`, `reg_we` and `reg_re` are low and `reg_addr` is 0.
- R2: An address byte whose upper seven bits equal `dev_addr` is acknowledged by pulling SDA low for the ninth clock. Any other address gets no acknowledge. The target then drives nothing, strobes nothing and leaves the pointer unchanged until the next start or stop.
- R3: Each byte takes nine SCL clocks: eight data bits, MSB first, then an acknowledge bit. When addressed in a write, the target acknowledges every byte it receives.
- R4: In a write, the first two bytes after the address byte (direction bit 0) load the register pointer, high byte first.
- R5: Every later byte of a write is written with a one-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments. A write may carry any number of bytes.
- R6: In a read (direction bit 1), each byte sent MSB first is the register content at the pointer. It is fetched with a one-cycle `reg_re` pulse and `reg_rdata` is taken one cycle later, after which the pointer increments. A read with no pointer phase continues from the current pointer.
- R7: When the controller leaves SDA high in the ninth clock of a read byte (NACK), the target releases SDA and issues no further read strobe until a new start.
- R8: The pointer wraps from 65535 to 0.
- R9: A start or stop at any bit position abandons the byte in progress: a partial data byte is not written and a partial pointer byte does not change the pointer. A stop returns to idle with SDA released.
- R10: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Device address to match |
| scl_i | input | 1 | SCL line sample |
| sda_i | input | 1 | SDA line sample |
| sda_oe | output | 1 | SDA pull-down enable (1 = drive low) |
| reg_addr | output | 16 | Register pointer / access address |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_re |
| reg_re | output | 1 | One-cycle read strobe |

## Verification
On every cycle the assertions check several properties. SDA output changes only while SCL is low. Write strobes occur only on entry to the write-data acknowledge. Read strobes occur only in the address acknowledge or the read acknowledge. Each strobe advances the pointer by exactly one with wraparound. A stop returns the machine to idle with SDA released, and the skip state never drives the line. Only the bench scenarios can show the byte-level results over a whole transaction. These are: address match and mismatch, which bytes get written and at which pointer value, the data shifted out in a burst read, pointer continuation and wrap, the effect of a NACK, and the loss of a partial byte on a stop or repeated start.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_PTRH,
        ST_PTRH_ACK,
        ST_PTRL,
        ST_PTRL_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic scl_s;
        logic sda_s;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync #(
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output i2c_tgt_pkg::line_ev_t ev
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff[0] <= 1'b1;
                    sda_ff[0] <= 1'b1;
                end else begin
                    scl_ff[0] <= scl_i;
                    sda_ff[0] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_ff[g-1];
                    sda_ff[g] <= sda_ff[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_ff[STAGES-1];
            sda_p <= sda_ff[STAGES-1];
        end
    end

    always_comb begin
        ev.scl_s    = scl_ff[STAGES-1];
        ev.sda_s    = sda_ff[STAGES-1];
        ev.scl_rise = scl_ff[STAGES-1] & ~scl_p;
        ev.scl_fall = ~scl_ff[STAGES-1] & scl_p;
        ev.start    = scl_ff[STAGES-1] & scl_p & sda_p & ~sda_ff[STAGES-1];
        ev.stop     = scl_ff[STAGES-1] & scl_p & ~sda_p & sda_ff[STAGES-1];
    end
endmodule

// File: rtl/i2c_tgt_shifter.sv
module i2c_tgt_shifter #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sample,
    input  logic              bit_in,
    output logic [DATA_W-1:0] rx_byte,
    output logic              byte_full
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rx_byte <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (sample) begin
            rx_byte <= {rx_byte[DATA_W-2:0], bit_in};
            if (cnt_q != '1) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign byte_full = (cnt_q == CNT_W'(DATA_W));
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int DEV_W      = DATA_W - 1,
    localparam int PTR_W      = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_re
);
    line_ev_t          ev;
    logic              scl_s;
    logic              stop_det;
    logic [DATA_W-1:0] rx_byte;
    logic              byte_full;
    logic              addr_match;

    tgt_state_e        state_q;
    tgt_state_e        state_d;

    logic              cnt_clr;
    logic              tx_load;
    logic              tx_shift;
    logic              ptr_load;
    logic              hi_cap;
    logic              rw_cap;
    logic              we_set;
    logic              re_set;
    logic              oe_d;

    logic              rw_q;
    logic              re_d;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] txbuf_q;

    assign scl_s    = ev.scl_s;
    assign stop_det = ev.stop;

    i2c_tgt_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_tgt_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .sample    (ev.scl_rise),
        .bit_in    (ev.sda_s),
        .rx_byte   (rx_byte),
        .byte_full (byte_full)
    );

    i2c_tgt_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val ({hi_q, rx_byte}),
        .inc      (reg_we | reg_re),
        .ptr      (reg_addr)
    );

    assign addr_match = (rx_byte[DATA_W-1:1] == dev_addr);

    // next state and control decode
    always_comb begin
        state_d  = state_q;
        oe_d     = sda_oe;
        cnt_clr  = 1'b0;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        ptr_load = 1'b0;
        hi_cap   = 1'b0;
        rw_cap   = 1'b0;
        we_set   = 1'b0;
        re_set   = 1'b0;
        if (ev.stop) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
            cnt_clr = 1'b1;
        end else if (ev.start) begin
            state_d = ST_DEVADDR;
            oe_d    = 1'b0;
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: begin
                    oe_d = 1'b0;
                end
                ST_DEVADDR: begin
                    if (ev.scl_fall && byte_full) begin
                        if (addr_match) begin
                            state_d = ST_DEVACK;
                            oe_d    = 1'b1;
                            rw_cap  = 1'b1;
                            re_set  = rx_byte[0];
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
                ST_DEVACK: begin
                    if (ev.scl_fall) begin
                        cnt_clr = 1'b1;
                        if (rw_q) begin
                            state_d = ST_RDATA;
                            tx_load = 1'b1;
                            oe_d    = ~txbuf_q[DATA_W-1];
                        end else begin
                            state_d = ST_PTRH;
                            oe_d    = 1'b0;
                        end
                    end
                end
                ST_PTRH: begin
                    if (ev.scl_fall && byte_full) begin
                        state_d = ST_PTRH_ACK;
                        oe_d    = 1'b1;
                        hi_cap  = 1'b1;
                    end
                end
                ST_PTRH_ACK: begin
                    if (ev.scl_fall) begin
                        state_d = ST_PTRL;
                        oe_d    = 1'b0;
                        cnt_clr = 1'b1;
                    end
                end
                ST_PTRL: begin
                    if (ev.scl_fall && byte_full) begin
                        state_d  = ST_PTRL_ACK;
                        oe_d     = 1'b1;
                        ptr_load = 1'b1;
                    end
                end
                ST_PTRL_ACK: begin
                    if (ev.scl_fall) begin
                        state_d = ST_WDATA;
                        oe_d    = 1'b0;
                        cnt_clr = 1'b1;
                    end
                end
                ST_WDATA: begin
                    if (ev.scl_fall && byte_full) begin
                        state_d = ST_WDATA_ACK;
                        oe_d    = 1'b1;
                        we_set  = 1'b1;
                    end
                end
                ST_WDATA_ACK: begin
                    if (ev.scl_fall) begin
                        state_d = ST_WDATA;
                        oe_d    = 1'b0;
                        cnt_clr = 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (ev.scl_fall) begin
                        if (byte_full) begin
                            state_d = ST_RD_ACK;
                            oe_d    = 1'b0;
                        end else begin
                            tx_shift = 1'b1;
                            oe_d     = ~tx_q[DATA_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev.scl_rise) begin
                        if (ev.sda_s) begin
                            state_d = ST_SKIP;
                        end else begin
                            re_set = 1'b1;
                        end
                    end else if (ev.scl_fall) begin
                        state_d = ST_RDATA;
                        tx_load = 1'b1;
                        cnt_clr = 1'b1;
                        oe_d    = ~txbuf_q[DATA_W-1];
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    oe_d    = 1'b0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
            reg_wdata <= '0;
            re_d      <= 1'b0;
            rw_q      <= 1'b0;
            hi_q      <= '0;
            tx_q      <= '0;
            txbuf_q   <= '0;
        end else begin
            sda_oe <= oe_d;
            reg_we <= we_set;
            reg_re <= re_set;
            re_d   <= reg_re;
            if (we_set) begin
                reg_wdata <= rx_byte;
            end
            if (rw_cap) begin
                rw_q <= rx_byte[0];
            end
            if (hi_cap) begin
                hi_q <= rx_byte;
            end
            if (re_d) begin
                txbuf_q <= reg_rdata;
            end
            if (tx_load) begin
                tx_q <= txbuf_q;
            end else if (tx_shift) begin
                tx_q <= {tx_q[DATA_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             stop_det,
    input tgt_state_e       state,
    input logic             sda_oe,
    input logic             reg_we,
    input logic             reg_re,
    input logic [PTR_W-1:0] reg_addr
);
    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R5
    we_in_wack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (state == ST_WDATA_ACK));

    // R6
    re_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> (state == ST_DEVACK || state == ST_RD_ACK));

    // R8
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R2
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!sda_oe && !reg_we && !reg_re));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .state    (state_q),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr)
);

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;
    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda_low = 1'b0;
    logic        sda_oe;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_we;
    logic [7:0]  reg_rdata;
    logic        reg_re;
    wire         sda_bus = ~(m_sda_low | sda_oe);

    int nchk = 0;
    int nfail = 0;
    logic [7:0]  mem [0:255];
    logic [15:0] log_a [0:31];
    logic [7:0]  log_d [0:31];
    int wcnt = 0;
    int rcnt = 0;

    always #2.5 clk = ~clk;

    i2c_reg_target u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_addr  (DEV),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .reg_re    (reg_re)
    );

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    end

    // register file model: read data registered one cycle after strobe
    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr[7:0]] <= reg_wdata;
            if (wcnt < 32) begin
                log_a[wcnt] <= reg_addr;
                log_d[wcnt] <= reg_wdata;
            end
            wcnt <= wcnt + 1;
        end
        if (reg_re) begin
            reg_rdata <= mem[reg_addr[7:0]] ^ reg_addr[15:8];
            rcnt <= rcnt + 1;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [15:0] a);
        return mem[a[7:0]] ^ a[15:8];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda_low = 1'b0; t(Q);
        m_scl = 1'b1;     t(Q);
        m_sda_low = 1'b1; t(Q);
        m_scl = 1'b0;     t(Q);
    endtask

    task automatic bus_stop;
        m_sda_low = 1'b1; t(Q);
        m_scl = 1'b1;     t(Q);
        m_sda_low = 1'b0; t(2 * Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda_low = ~b; t(Q);
        m_scl = 1'b1;   t(2 * Q);
        m_scl = 1'b0;   t(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda_low = 1'b0; t(Q);
        m_scl = 1'b1;     t(Q);
        b = sda_bus;      t(Q);
        m_scl = 1'b0;     t(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic sc_reset;
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 reg_we", int'(reg_we), 0);
        chk("R1 reg_re", int'(reg_re), 0);
        chk("R1 reg_addr", int'(reg_addr), 0);
    endtask

    task automatic sc_wrong_addr;
        logic ack;
        logic [7:0] v;
        int w0, r0;
        w0 = wcnt; r0 = rcnt;
        bus_start;
        send_byte({7'h23, 1'b0}, ack);
        chk("R2 no ack on mismatch (write)", int'(ack), 0);
        send_byte(8'h00, ack);
        chk("R2 ignored byte not acked", int'(ack), 0);
        send_byte(8'h10, ack);
        send_byte(8'h99, ack);
        bus_stop;
        bus_start;
        send_byte({7'h23, 1'b1}, ack);
        chk("R2 no ack on mismatch (read)", int'(ack), 0);
        recv_byte(1'b0, v);
        chk("R2 line stays released", int'(v), 8'hFF);
        bus_stop;
        chk("R2 no write strobe", wcnt - w0, 0);
        chk("R2 no read strobe", rcnt - r0, 0);
        chk("R2 pointer unchanged", int'(reg_addr), 0);
    endtask

    task automatic sc_write_burst;
        logic ack;
        int w0;
        logic [7:0] dat [3];
        dat[0] = 8'hA5; dat[1] = 8'h5A; dat[2] = 8'h3C;
        w0 = wcnt;
        bus_start;
        send_byte({DEV, 1'b0}, ack);
        chk("R2 ack on match", int'(ack), 1);
        send_byte(8'h12, ack);
        chk("R4 ptr high acked", int'(ack), 1);
        send_byte(8'h34, ack);
        chk("R4 ptr low acked", int'(ack), 1);
        for (int i = 0; i < 3; i++) begin
            send_byte(dat[i], ack);
            chk("R3 data byte acked", int'(ack), 1);
        end
        bus_stop;
        chk("R5 write count", wcnt - w0, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R5 write address", int'(log_a[w0 + i]), 16'h1234 + i);
            chk("R5 write data", int'(log_d[w0 + i]), int'(dat[i]));
        end
        chk("R5 pointer after burst", int'(reg_addr), 16'h1237);
        chk("R9 released after stop", int'(sda_oe), 0);
    endtask

    task automatic sc_read_burst;
        logic ack;
        logic [7:0] v;
        logic [7:0] e [3];
        int r0;
        for (int i = 0; i < 3; i++) e[i] = exp_rd(16'h1234 + 16'(i));
        bus_start;
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h12, ack);
        send_byte(8'h34, ack);
        bus_start;
        send_byte({DEV, 1'b1}, ack);
        chk("R6 read address acked", int'(ack), 1);
        recv_byte(1'b1, v);
        chk("R6 read byte 0", int'(v), int'(e[0]));
        recv_byte(1'b1, v);
        chk("R6 read byte 1", int'(v), int'(e[1]));
        recv_byte(1'b0, v);
        chk("R6 read byte 2", int'(v), int'(e[2]));
        r0 = rcnt;
        t(4 * Q);
        chk("R7 released after NACK", int'(sda_oe), 0);
        chk("R7 no strobe after NACK", rcnt - r0, 0);
        bus_stop;
        chk("R6 pointer after read", int'(reg_addr), 16'h1237);
    endtask

    task automatic sc_read_continue;
        logic ack;
        logic [7:0] v;
        logic [7:0] e;
        e = exp_rd(16'h1237);
        bus_start;
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, v);
        chk("R6 read continues from pointer", int'(v), int'(e));
        bus_stop;
        chk("R6 pointer advanced", int'(reg_addr), 16'h1238);
    endtask

    task automatic sc_wrap;
        logic ack;
        int w0;
        w0 = wcnt;
        bus_start;
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'hFF, ack);
        send_byte(8'hFF, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        bus_stop;
        chk("R8 write count", wcnt - w0, 2);
        chk("R8 top address", int'(log_a[w0]), 16'hFFFF);
        chk("R8 wrapped address", int'(log_a[w0 + 1]), 16'h0000);
        chk("R8 wrapped data", int'(log_d[w0 + 1]), 8'h22);
        chk("R8 pointer after wrap", int'(reg_addr), 16'h0001);
    endtask

    task automatic sc_abort;
        logic ack;
        logic [7:0] v;
        logic [7:0] e;
        int w0;
        w0 = wcnt;
        bus_start;
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h00, ack);
        send_byte(8'h40, ack);
        send_byte(8'h77, ack);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop;
        chk("R9 partial data byte dropped", wcnt - w0, 1);
        chk("R9 pointer after abort", int'(reg_addr), 16'h0041);
        e = exp_rd(16'h0041);
        bus_start;
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h00, ack);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_start;
        send_byte({DEV, 1'b1}, ack);
        chk("R9 address after repeated start", int'(ack), 1);
        recv_byte(1'b0, v);
        chk("R9 partial pointer ignored", int'(v), int'(e));
        bus_stop;
        chk("R9 pointer after read", int'(reg_addr), 16'h0042);
        chk("R9 no stray writes", wcnt - w0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        t(10);
        rst_n = 1'b1;
        t(5);
        sc_reset;
        sc_wrong_addr;
        sc_write_burst;
        sc_read_burst;
        sc_read_continue;
        sc_wrap;
        sc_abort;
        t(20);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule